// File: doc/BRIEF.md
# Two-Bit-Opcode Accumulator Processor Core

This block is a very small 8-bit processor built around a single accumulator. Program and data share one external byte memory of 64 locations. Every instruction is one byte. The upper two bits select one of four operations. The lower six bits give a direct memory address. The core provides the address, write data and write strobe for a synchronous memory, and it takes back the read data one clock after it presents an address.

A host loads the shared memory through its own path while the core is halted. It then lets the core run freely with `run_i`, or advances it one instruction at a time with rising edges on `step_i`. The program counter, accumulator and carry flag are always visible on observation outputs. `halted_o` tells the host that the core is resting at an instruction boundary.

The four operations are a no-operation, an add from memory into the accumulator, a store that also clears the accumulator and carry, and a jump that is taken only while carry is clear. A jump to its own address gives an endless loop, which is how programs end.

Top module: `acc_core`

## Requirements
- R1: While reset (active-low `rst_n`) is held and right after its release, the outputs show `pc_o`=0, `acc_o`=0, `carry_o`=0 and `mem_we_o`=0. With `run_i` and `step_i` low, `halted_o` is 1.
- R2: An instruction byte holds the opcode in bits 7:6 and a direct address in bits 5:0. The core places the PC on `mem_addr_o` in the fetch cycle and expects the byte on `mem_rdata_i` one clock later.
- R3: Opcode 01 (add) sets the accumulator to (accumulator + memory[address]) mod 256 and sets carry to the carry out of bit 7. It then advances the PC by one. The instruction takes three clocks: fetch, operand read and accumulate.
- R4: Opcode 10 (store-and-clear) writes the accumulator to memory[address] with `mem_we_o` high for one clock. It then sets the accumulator and carry to 0 and advances the PC by one, in two clocks.
- R5: Opcode 11 (jump) loads the PC with the address when carry is 0, and advances the PC by one when carry is 1. It takes two clocks.
- R6: Opcode 00 only advances the PC by one. It leaves the accumulator and carry unchanged and writes nothing, in two clocks.
- R7: With `run_i` low and no step edge, the core stays at the instruction boundary. `halted_o` is 1, the PC, accumulator and carry hold their values, and no write occurs.
- R8: With `run_i` low, each rising edge of `step_i` executes exactly one instruction. Holding `step_i` high executes no further instruction.
- R9: `mem_we_o` is asserted only for store-and-clear, for exactly one clock per such instruction.
- R10: Memory holding C4 27 43 00 83 41 42 83 C8 at addresses 0..8 and run freely leaves 0x6A at address 3, with the PC parked at 8.
- R11: The PC wraps from 63 to 0 when it advances past the last location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Free-running execution while high |
| step_i | input | 1 | Rising edge executes one instruction while run_i is low |
| mem_addr_o | output | 6 | Memory address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_we_o | output | 1 | Memory write strobe |
| mem_rdata_i | input | 8 | Memory read data, valid one clock after its address |
| halted_o | output | 1 | Core idle at an instruction boundary |
| pc_o | output | 6 | Program counter observation |
| acc_o | output | 8 | Accumulator observation |
| carry_o | output | 1 | Carry flag observation |

## Verification
The bench builds the core with its default 8-bit data width, which gives a 6-bit address and a 64-byte memory. At that size a random program fills the whole memory. Jumps land on data bytes as often as on code, and the wrap from address 63 back to 0 comes up within a few dozen steps. Every step is compared with a reference model. Directed programs cover carry-blocked jumps, the wrap itself and the example program run freely.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

    localparam int OPC_W = 2;

    typedef enum logic [OPC_W-1:0] {
        OP_NOP = 2'b00,
        OP_ADD = 2'b01,
        OP_SAC = 2'b10,
        OP_JCC = 2'b11
    } opcode_e;

    typedef enum logic [1:0] {
        ST_FETCH = 2'd0,
        ST_EXEC  = 2'd1,
        ST_ACCUM = 2'd2
    } state_e;

endpackage

// File: rtl/acc_core_decode.sv
module acc_core_decode
    import acc_core_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = DATA_W - OPC_W
) (
    input  logic [DATA_W-1:0] instr_i,
    input  logic              carry_i,
    output opcode_e           op_o,
    output logic [ADDR_W-1:0] operand_o,
    output logic              jump_o
);

    // opcode sits in the top bits, direct address in the rest (R2)
    always_comb begin
        op_o      = opcode_e'(instr_i[DATA_W-1 -: OPC_W]);
        operand_o = instr_i[ADDR_W-1:0];
        jump_o    = (op_o == OP_JCC) && !carry_i;
    end

endmodule

// File: rtl/acc_core_adder.sv
module acc_core_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);

    logic [W:0] chain;

    assign chain[0] = 1'b0;

    // ripple chain, one full adder per bit
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum_o[i]     = a_i[i] ^ b_i[i] ^ chain[i];
        assign chain[i + 1] = (a_i[i] & b_i[i]) | (chain[i] & (a_i[i] ^ b_i[i]));
    end

    assign cout_o = chain[W];

    always_comb begin
        assert_add_wide_R3: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i}))
            else $error("adder result mismatch");
    end

endmodule

// File: rtl/acc_core_stepctl.sv
module acc_core_stepctl (
    input  logic clk,
    input  logic rst_n,
    input  logic step_i,
    input  logic consume_i,
    output logic go_o
);

    typedef struct packed {
        logic prev;
        logic pend;
    } step_regs_t;

    step_regs_t s_d, s_q;
    logic       edge_seen;

    always_comb begin
        edge_seen = step_i && !s_q.prev;
        go_o      = s_q.pend || edge_seen;
        s_d.prev  = step_i;
        if (consume_i) begin
            s_d.pend = 1'b0;
        end else begin
            s_d.pend = go_o;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // a held step level never re-arms a request (R8)
    assert_held_step_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (consume_i && s_q.prev && step_i) |=> !s_q.pend)
        else $error("held step re-armed a request");

endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_core_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int ADDR_W = DATA_W - OPC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic              mem_we_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              halted_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic [DATA_W-1:0] acc_o,
    output logic              carry_o
);

    typedef struct packed {
        state_e            st;
        logic [ADDR_W-1:0] pc;
        logic [DATA_W-1:0] acc;
        logic              cy;
    } core_regs_t;

    core_regs_t r_d, r_q;

    opcode_e           dec_op;
    logic [ADDR_W-1:0] dec_operand;
    logic              dec_jump;
    logic [DATA_W-1:0] add_sum;
    logic              add_cout;
    logic              step_go;
    logic              consume;
    logic [ADDR_W-1:0] pc_inc;

    acc_core_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_decode (
        .instr_i   (mem_rdata_i),
        .carry_i   (r_q.cy),
        .op_o      (dec_op),
        .operand_o (dec_operand),
        .jump_o    (dec_jump)
    );

    acc_core_adder #(.W(DATA_W)) u_adder (
        .a_i    (r_q.acc),
        .b_i    (mem_rdata_i),
        .sum_o  (add_sum),
        .cout_o (add_cout)
    );

    acc_core_stepctl u_stepctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (step_i),
        .consume_i (consume),
        .go_o      (step_go)
    );

    always_comb begin
        r_d         = r_q;
        pc_inc      = r_q.pc + 1'b1;
        mem_addr_o  = r_q.pc;
        mem_wdata_o = r_q.acc;
        mem_we_o    = 1'b0;
        consume     = 1'b0;
        case (r_q.st)
            ST_FETCH: begin
                if (run_i || step_go) begin
                    consume = 1'b1;
                    r_d.st  = ST_EXEC;
                end
            end
            ST_EXEC: begin
                r_d.st = ST_FETCH;
                case (dec_op)
                    OP_NOP: r_d.pc = pc_inc;
                    OP_ADD: begin
                        mem_addr_o = dec_operand;
                        r_d.st     = ST_ACCUM;
                    end
                    OP_SAC: begin
                        mem_addr_o = dec_operand;
                        mem_we_o   = 1'b1;
                        r_d.acc    = '0;
                        r_d.cy     = 1'b0;
                        r_d.pc     = pc_inc;
                    end
                    OP_JCC: r_d.pc = dec_jump ? dec_operand : pc_inc;
                    default: r_d.pc = pc_inc;
                endcase
            end
            ST_ACCUM: begin
                r_d.acc = add_sum;
                r_d.cy  = add_cout;
                r_d.pc  = pc_inc;
                r_d.st  = ST_FETCH;
            end
            default: r_d.st = ST_FETCH;
        endcase
        halted_o = (r_q.st == ST_FETCH) && !run_i && !step_go;
        pc_o     = r_q.pc;
        acc_o    = r_q.acc;
        carry_o  = r_q.cy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_FETCH, pc: '0, acc: '0, cy: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |=> ($stable(pc_o) && $stable(acc_o) && $stable(carry_o)))
        else $error("state moved while halted");

    assert_store_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |=> (acc_o == '0 && !carry_o))
        else $error("store did not clear accumulator");

    assert_single_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |=> !mem_we_o)
        else $error("write strobe longer than one clock");

    assert_jump_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_EXEC && dec_op == OP_JCC && !carry_o) |=> (pc_o == $past(dec_operand)))
        else $error("jump with carry clear not taken");

    assert_nop_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_EXEC && dec_op == OP_NOP) |=> ($stable(acc_o) && $stable(carry_o)))
        else $error("no-op changed accumulator or carry");

    assert_step_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_FETCH && step_go) |=> (r_q.st == ST_EXEC))
        else $error("step request did not start an instruction");

endmodule

// File: tb/sim_acc_core.sv
`timescale 1ns/1ps
module sim_acc_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0;
    logic       step = 1'b0;
    logic [5:0] core_addr;
    logic [7:0] core_wdata;
    logic       core_we;
    logic [7:0] rdata;
    logic       halted;
    logic [5:0] pc;
    logic [7:0] acc;
    logic       carry;

    logic       host_we = 1'b0;
    logic [5:0] host_addr = '0;
    logic [7:0] host_data = '0;

    logic [7:0] mem [64];
    logic [7:0] m_mem [64];
    logic [5:0] m_pc;
    logic [7:0] m_acc;
    logic       m_cy;

    int checks = 0;
    int fails = 0;
    int wr_cnt = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    acc_core u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (run),
        .step_i      (step),
        .mem_addr_o  (core_addr),
        .mem_wdata_o (core_wdata),
        .mem_we_o    (core_we),
        .mem_rdata_i (rdata),
        .halted_o    (halted),
        .pc_o        (pc),
        .acc_o       (acc),
        .carry_o     (carry)
    );

    always @(posedge clk) begin
        if (host_we) mem[host_addr] <= host_data;
        else if (core_we) mem[core_addr] <= core_wdata;
        rdata <= mem[core_addr];
        if (rst_n && core_we) wr_cnt <= wr_cnt + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic load(input logic [7:0] img [64]);
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            host_we = 1'b1; host_addr = 6'(i); host_data = img[i];
            m_mem[i] = img[i];
        end
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; run = 1'b0; step = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_pc = '0; m_acc = '0; m_cy = 1'b0;
    endtask

    // reference model of one instruction; returns expected clocks
    function automatic int model_step(output bit wrote, output logic [5:0] waddr);
        logic [7:0] ins = m_mem[m_pc];
        logic [5:0] opd = ins[5:0];
        logic [8:0] s;
        wrote = 1'b0; waddr = opd;
        case (ins[7:6])
            2'b01: begin
                s = {1'b0, m_acc} + {1'b0, m_mem[opd]};
                m_acc = s[7:0]; m_cy = s[8]; m_pc = m_pc + 1'b1;
                return 3;
            end
            2'b10: begin
                m_mem[opd] = m_acc; m_acc = '0; m_cy = 1'b0;
                m_pc = m_pc + 1'b1; wrote = 1'b1;
            end
            2'b11: m_pc = m_cy ? m_pc + 1'b1 : opd;
            default: m_pc = m_pc + 1'b1;
        endcase
        return 2;
    endfunction

    task automatic do_step(output int cyc);
        @(negedge clk);
        step = 1'b1; cyc = 0;
        @(negedge clk);
        step = 1'b0; cyc = 1;
        while (!halted && cyc < 20) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic step_and_check(input string tag);
        int cyc;
        int w0;
        int exp_cyc;
        bit wrote;
        logic [5:0] wa;
        w0 = wr_cnt;
        exp_cyc = model_step(wrote, wa);
        do_step(cyc);
        check(pc == m_pc && acc == m_acc && carry == m_cy, tag,
              {pc, acc, 7'(carry)}, {m_pc, m_acc, 7'(m_cy)});
        check(cyc == exp_cyc, "R3 clocks per instruction", cyc, exp_cyc);
        check((wr_cnt - w0) == int'(wrote), "R9 write count", wr_cnt - w0, int'(wrote));
        if (wrote) check(mem[wa] == m_mem[wa], "R4 stored byte", mem[wa], m_mem[wa]);
    endtask

    initial begin
        logic [7:0] img [64];
        void'($urandom(32'd20240611));

        // R1 reset state
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(pc == 0 && acc == 0 && carry == 0 && !core_we, "R1 in reset", {pc, acc}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(pc == 0 && acc == 0 && carry == 0 && halted, "R1 after release", {pc, acc, 7'(halted)}, 1);

        // R7 idle with no run or step
        for (int i = 0; i < 64; i++) img[i] = 8'h41;
        load(img);
        do_reset();
        begin
            int w0 = wr_cnt;
            repeat (20) @(negedge clk);
            check(pc == 0 && acc == 0 && halted && wr_cnt == w0, "R7 idle hold", {pc, acc}, 0);
        end

        // R10 example program run freely
        for (int i = 0; i < 64; i++) img[i] = 8'h00;
        img[0] = 8'hC4; img[1] = 8'h27; img[2] = 8'h43; img[3] = 8'h00;
        img[4] = 8'h83; img[5] = 8'h41; img[6] = 8'h42; img[7] = 8'h83; img[8] = 8'hC8;
        load(img);
        do_reset();
        run = 1'b1;
        repeat (60) @(negedge clk);
        run = 1'b0;
        repeat (4) @(negedge clk);
        check(mem[3] == 8'h6A, "R10 sum at address 3", mem[3], 8'h6A);
        check(pc == 6'd8 && halted, "R10 parked at 8", pc, 8);

        // same program stepped, R2 R4 R5 against model
        load(img);
        do_reset();
        for (int i = 0; i < 8; i++) step_and_check("R2 stepped example");

        // R8 held step executes once
        do_reset();
        @(negedge clk);
        step = 1'b1;
        repeat (12) @(negedge clk);
        check(pc == 6'd4, "R8 held step", pc, 4);
        step = 1'b0;
        @(negedge clk);

        // directed: carry-blocked jump, no-op, store, wrap (R3 R5 R6 R11)
        for (int i = 0; i < 64; i++) img[i] = 8'h00;
        img[0] = 8'h4A; img[1] = 8'h4B; img[2] = 8'hC0; img[3] = 8'h00;
        img[4] = 8'h8C; img[5] = 8'hFF; img[10] = 8'hF0; img[11] = 8'h20;
        load(img);
        do_reset();
        step_and_check("R3 add F0");
        step_and_check("R3 add with carry out");
        check(carry == 1'b1 && acc == 8'h10, "R3 carry set", {acc, 7'(carry)}, 8'h10 * 128 + 1);
        step_and_check("R5 jump blocked");
        check(pc == 6'd3, "R5 fall through", pc, 3);
        step_and_check("R6 no-op");
        check(acc == 8'h10 && carry == 1'b1, "R6 state kept", acc, 8'h10);
        step_and_check("R4 store and clear");
        check(mem[12] == 8'h10 && acc == 0 && carry == 0, "R4 stored", mem[12], 8'h10);
        step_and_check("R5 jump taken");
        check(pc == 6'd63, "R5 target 63", pc, 63);
        step_and_check("R11 wrap");
        check(pc == 6'd0, "R11 pc wrapped", pc, 0);

        // random programs, stepped against the model
        for (int p = 0; p < 25; p++) begin
            for (int i = 0; i < 64; i++) img[i] = 8'($urandom);
            load(img);
            do_reset();
            for (int s = 0; s < 40; s++) step_and_check("R2 random program");
            begin
                int bad = 0;
                for (int i = 0; i < 64; i++) if (mem[i] != m_mem[i]) bad++;
                check(bad == 0, "R4 random memory image", bad, 0);
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule